// File: doc/BRIEF.md
# Serial Port Interrupt Aggregator

This block gathers the ten status flags of a serial port into three interrupt request lines: one for the transmitter, one for the receiver and one for error conditions. Each flag has its own enable bit. An enable bit only decides whether its flag takes part in a request. The flag itself can always be read on the flag outputs.

There are two transmit flags, buffer-empty and transfer-done. They are not stored. They are status levels derived each cycle from the transmitter's queue occupancy, its shifter activity and the level of its output line. There are four receive flags and four error flags. These are sticky: a one-cycle event pulse sets a flag, and a software clear strobe resets it. The transmitter and receiver datapaths are outside this block; their events arrive on the event and status inputs. The block has no data stream, so it has no valid/ready handshake, and every pin is a plain control or status signal. Each request output is registered, so it follows its flags and enables one cycle later without glitches.

Top module: `uart_irq_hub`

## Requirements
- R1: While `rst_n` is low, all receive and error flags read 0 and all three request outputs read 0.
- R2: A 1 on bit i of `rx_evt_set` or `err_evt_set` sets flag i of the matching group at the next clock edge. The flag then holds its value until a clear strobe arrives.
- R3: A 1 on bit i of `rx_flag_clr` or `err_flag_clr` clears flag i at the next edge. If the set pulse and the clear strobe for the same flag arrive in the same cycle, the flag ends up set.
- R4: `tx_empty_flag` is 1 in the same cycle whenever `tx_fill` is below `TX_DEPTH`, and 0 when the queue is full.
- R5: `tx_done_flag` is 1 in the same cycle only when `tx_fill` is 0, `tx_active` is 0 and `tx_line` is high (high is the idle level). Otherwise it is 0.
- R6: `irq_tx` equals, one cycle later, (buffer-empty AND `irq_en[0]`) OR (transfer-done AND `irq_en[1]`).
- R7: `irq_rx` equals, one cycle later, the OR over i of `rx_flags[i]` AND `irq_en[2+i]`. The receive flags are bit 0 data-ready, bit 1 idle-line, bit 2 pin-edge and bit 3 break.
- R8: `irq_err` equals, one cycle later, the OR over i of `err_flags[i]` AND `irq_en[6+i]`. The error flags are bit 0 overrun, bit 1 noise, bit 2 framing and bit 3 parity.
- R9: A flag whose enable bit is 0 never raises a request, but its value still appears on the flag outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_evt_set | input | 4 | Receive event pulses (data-ready, idle, pin-edge, break) |
| rx_flag_clr | input | 4 | Receive flag clear strobes |
| err_evt_set | input | 4 | Error event pulses (overrun, noise, framing, parity) |
| err_flag_clr | input | 4 | Error flag clear strobes |
| irq_en | input | 10 | Per-source enables: [1:0] transmit, [5:2] receive, [9:6] error |
| tx_fill | input | CNT_W | Number of characters waiting in the transmit queue |
| tx_active | input | 1 | Shifter is sending data, preamble or break |
| tx_line | input | 1 | Present level of the transmit line |
| tx_empty_flag | output | 1 | Transmit queue has room |
| tx_done_flag | output | 1 | Transmitter finished and line idle |
| rx_flags | output | 4 | Sticky receive flags |
| err_flags | output | 4 | Sticky error flags |
| irq_tx | output | 1 | Transmit request |
| irq_rx | output | 1 | Receive request |
| irq_err | output | 1 | Error request |

## Verification
The transmit status is tried with a full queue, a partly filled queue with the shifter busy, and an empty queue with the line held low and then high. These cases separate buffer-empty from transfer-done and show the line-level condition. For the sticky groups, a single flag is set with every enable off and then with only its own enable on, which shows whether the source-to-request mapping is correct. An enable on a neighbouring bit catches any shifted grouping. Set and clear strobes arrive both alone and together on the same flag, so that the set-wins rule and the hold behaviour can be distinguished.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int N_TX  = 2;
  localparam int N_RX  = 4;
  localparam int N_ERR = 4;
  localparam int N_SRC = N_TX + N_RX + N_ERR;
  localparam int TX_EN_LO  = 0;
  localparam int RX_EN_LO  = TX_EN_LO + N_TX;
  localparam int ERR_EN_LO = RX_EN_LO + N_RX;
endpackage

// File: rtl/uirq_sticky_bank.sv
module uirq_sticky_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_o[i] <= 1'b0;
      else if (set_i[i]) flag_o[i] <= 1'b1;   // set has priority
      else if (clr_i[i]) flag_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/uirq_tx_status.sv
module uirq_tx_status #(
  parameter int DEPTH = 2,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] fill_i,
  input  logic          active_i,
  input  logic          line_i,
  output logic          empty_o,
  output logic          done_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  always_comb begin
    empty_o = (fill_i < FULL);
    done_o  = (fill_i == '0) && !active_i && line_i;
  end
endmodule

// File: rtl/uirq_req_reduce.sv
module uirq_req_reduce #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flag_i,
  input  logic [W-1:0] en_i,
  output logic         req_o
);
  logic any_w;
  assign any_w = |(flag_i & en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_o <= 1'b0;
    else        req_o <= any_w;
  end
endmodule

// File: rtl/uart_irq_hub.sv
module uart_irq_hub
  import uirq_pkg::*;
#(
  parameter int TX_DEPTH = 2,
  parameter int CNT_W    = $clog2(TX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       rx_evt_set,
  input  logic [3:0]       rx_flag_clr,
  input  logic [3:0]       err_evt_set,
  input  logic [3:0]       err_flag_clr,
  input  logic [9:0]       irq_en,
  input  logic [CNT_W-1:0] tx_fill,
  input  logic             tx_active,
  input  logic             tx_line,
  output logic             tx_empty_flag,
  output logic             tx_done_flag,
  output logic [3:0]       rx_flags,
  output logic [3:0]       err_flags,
  output logic             irq_tx,
  output logic             irq_rx,
  output logic             irq_err
);
  logic [N_TX-1:0] tx_vec;

  uirq_tx_status #(.DEPTH(TX_DEPTH), .CW(CNT_W)) u_txs (
    .fill_i  (tx_fill),
    .active_i(tx_active),
    .line_i  (tx_line),
    .empty_o (tx_empty_flag),
    .done_o  (tx_done_flag)
  );
  assign tx_vec = {tx_done_flag, tx_empty_flag};

  uirq_sticky_bank #(.W(N_RX)) u_rx_bank (
    .clk(clk), .rst_n(rst_n),
    .set_i(rx_evt_set), .clr_i(rx_flag_clr), .flag_o(rx_flags)
  );

  uirq_sticky_bank #(.W(N_ERR)) u_err_bank (
    .clk(clk), .rst_n(rst_n),
    .set_i(err_evt_set), .clr_i(err_flag_clr), .flag_o(err_flags)
  );

  uirq_req_reduce #(.W(N_TX)) u_tx_req (
    .clk(clk), .rst_n(rst_n),
    .flag_i(tx_vec), .en_i(irq_en[TX_EN_LO +: N_TX]), .req_o(irq_tx)
  );

  uirq_req_reduce #(.W(N_RX)) u_rx_req (
    .clk(clk), .rst_n(rst_n),
    .flag_i(rx_flags), .en_i(irq_en[RX_EN_LO +: N_RX]), .req_o(irq_rx)
  );

  uirq_req_reduce #(.W(N_ERR)) u_err_req (
    .clk(clk), .rst_n(rst_n),
    .flag_i(err_flags), .en_i(irq_en[ERR_EN_LO +: N_ERR]), .req_o(irq_err)
  );
endmodule

// File: rtl/uirq_hub_chk.sv
module uirq_hub_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] rx_evt_set,
  input logic [3:0] rx_flag_clr,
  input logic [3:0] err_evt_set,
  input logic [3:0] err_flag_clr,
  input logic [9:0] irq_en,
  input logic       tx_empty_flag,
  input logic       tx_done_flag,
  input logic [3:0] rx_flags,
  input logic [3:0] err_flags,
  input logic       irq_tx,
  input logic       irq_rx,
  input logic       irq_err
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  for (genvar i = 0; i < 4; i++) begin : g_flag
    a_r2_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
      rx_evt_set[i] |=> rx_flags[i]);
    a_r2_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_evt_set[i] && !rx_flag_clr[i]) |=> $stable(rx_flags[i]));
    a_r3_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_flag_clr[i] && !rx_evt_set[i]) |=> !rx_flags[i]);
    a_r2_err_set: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt_set[i] |=> err_flags[i]);
    a_r3_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag_clr[i] && !err_evt_set[i]) |=> !err_flags[i]);
  end

  a_r5_done_implies_room: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_flag |-> tx_empty_flag);

  a_r6_tx_req: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> irq_tx == $past((tx_empty_flag & irq_en[0]) | (tx_done_flag & irq_en[1])));

  a_r7_rx_req: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> irq_rx == $past(|(rx_flags & irq_en[5:2])));

  a_r8_err_req: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> irq_err == $past(|(err_flags & irq_en[9:6])));

  a_r9_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 10'd0) |=> (!irq_tx && !irq_rx && !irq_err));
endmodule

bind uart_irq_hub uirq_hub_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .rx_evt_set(rx_evt_set), .rx_flag_clr(rx_flag_clr),
  .err_evt_set(err_evt_set), .err_flag_clr(err_flag_clr),
  .irq_en(irq_en),
  .tx_empty_flag(tx_empty_flag), .tx_done_flag(tx_done_flag),
  .rx_flags(rx_flags), .err_flags(err_flags),
  .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
);

// File: tb/uart_irq_hub_test.sv
`timescale 1ns/1ps
module uart_irq_hub_test;
  localparam int DEPTH = 2;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    rx_evt_set = '0, rx_flag_clr = '0, err_evt_set = '0, err_flag_clr = '0;
  logic [9:0]    irq_en = '0;
  logic [CW-1:0] tx_fill = '0;
  logic          tx_active = 1'b0, tx_line = 1'b1;
  logic          tx_empty_flag, tx_done_flag, irq_tx, irq_rx, irq_err;
  logic [3:0]    rx_flags, err_flags;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] m_rx = '0, m_err = '0;
  logic [12:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  uart_irq_hub #(.TX_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .rx_evt_set(rx_evt_set), .rx_flag_clr(rx_flag_clr),
    .err_evt_set(err_evt_set), .err_flag_clr(err_flag_clr),
    .irq_en(irq_en), .tx_fill(tx_fill), .tx_active(tx_active), .tx_line(tx_line),
    .tx_empty_flag(tx_empty_flag), .tx_done_flag(tx_done_flag),
    .rx_flags(rx_flags), .err_flags(err_flags),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  function automatic logic [12:0] observed();
    return {irq_err, irq_rx, irq_tx, err_flags, rx_flags, tx_done_flag, tx_empty_flag};
  endfunction

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the result expected after the edge.
  task automatic drive(input logic [3:0] rs, input logic [3:0] rc,
                       input logic [3:0] es, input logic [3:0] ec,
                       input logic [9:0] en, input int fill, input logic act,
                       input logic line, input string tag);
    logic te, td, it, ir, ie;
    @(negedge clk);
    rx_evt_set = rs; rx_flag_clr = rc; err_evt_set = es; err_flag_clr = ec;
    irq_en = en; tx_fill = CW'(fill); tx_active = act; tx_line = line;
    te = (fill < DEPTH);
    td = (fill == 0) && !act && line;
    it = (te & en[0]) | (td & en[1]);
    ir = |(m_rx & en[5:2]);
    ie = |(m_err & en[9:6]);
    m_rx  = rs | (m_rx & ~rc);
    m_err = es | (m_err & ~ec);
    exp_q.push_back({ie, ir, it, m_err, m_rx, td, te});
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  // Monitor: compares shortly after each edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) check(tag_q.pop_front(), observed(), exp_q.pop_front());
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    rx_evt_set = 4'hF; err_evt_set = 4'hF; irq_en = 10'h3FF;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset holds sticky flags and requests low (tx status is combinational: empty, done)
    check("R1", observed(), {3'b000, 4'h0, 4'h0, 1'b1, 1'b1});
    @(negedge clk);
    rx_evt_set = '0; err_evt_set = '0; irq_en = '0;
    rst_n = 1'b1;

    drive(4'h0, 4'h0, 4'h0, 4'h0, 10'h000, 0, 1'b0, 1'b1, "R9 tx flags visible, masked");
    drive(4'h0, 4'h0, 4'h0, 4'h0, 10'h001, 0, 1'b0, 1'b1, "R6 empty enabled");
    drive(4'h0, 4'h0, 4'h0, 4'h0, 10'h001, 2, 1'b0, 1'b1, "R4 queue full");
    drive(4'h0, 4'h0, 4'h0, 4'h0, 10'h002, 1, 1'b1, 1'b1, "R5 busy not done");
    drive(4'h0, 4'h0, 4'h0, 4'h0, 10'h002, 0, 1'b1, 1'b1, "R5 shifter active");
    drive(4'h0, 4'h0, 4'h0, 4'h0, 10'h002, 0, 1'b0, 1'b0, "R5 line low");
    drive(4'h0, 4'h0, 4'h0, 4'h0, 10'h002, 0, 1'b0, 1'b1, "R6 done enabled");
    drive(4'h0, 4'h0, 4'h0, 4'h0, 10'h002, 1, 1'b0, 1'b1, "R4 partial fill");
    drive(4'h1, 4'h0, 4'h0, 4'h0, 10'h000, 2, 1'b0, 1'b1, "R2 rx set masked");
    drive(4'h0, 4'h0, 4'h0, 4'h0, 10'h000, 2, 1'b0, 1'b1, "R9 rx flag held no irq");
    drive(4'h0, 4'h0, 4'h0, 4'h0, 10'h008, 2, 1'b0, 1'b1, "R7 neighbour enable");
    drive(4'h0, 4'h0, 4'h0, 4'h0, 10'h004, 2, 1'b0, 1'b1, "R7 data-ready enable");
    drive(4'h8, 4'h8, 4'h0, 4'h0, 10'h004, 2, 1'b0, 1'b1, "R3 set wins");
    drive(4'h0, 4'h1, 4'h0, 4'h0, 10'h020, 2, 1'b0, 1'b1, "R3 rx clear");
    drive(4'h0, 4'h0, 4'h0, 4'h0, 10'h020, 2, 1'b0, 1'b1, "R7 break enable");
    drive(4'h0, 4'h8, 4'h0, 4'h0, 10'h000, 2, 1'b0, 1'b1, "R3 break clear");
    drive(4'h4, 4'h0, 4'h0, 4'h0, 10'h010, 2, 1'b0, 1'b1, "R7 pin-edge");
    drive(4'h0, 4'h4, 4'h2, 4'h0, 10'h040, 2, 1'b0, 1'b1, "R8 noise set");
    drive(4'h0, 4'h0, 4'h0, 4'h0, 10'h040, 2, 1'b0, 1'b1, "R8 overrun enable only");
    drive(4'h0, 4'h0, 4'h0, 4'h0, 10'h080, 2, 1'b0, 1'b1, "R8 noise enable");
    drive(4'h0, 4'h0, 4'h8, 4'h2, 10'h200, 2, 1'b0, 1'b1, "R2 parity set noise clear");
    drive(4'h0, 4'h0, 4'h0, 4'h0, 10'h200, 2, 1'b0, 1'b1, "R8 parity enable");
    drive(4'h0, 4'h0, 4'h4, 4'h4, 10'h100, 2, 1'b0, 1'b1, "R3 err set wins");
    drive(4'h0, 4'h0, 4'h0, 4'hF, 10'h3FF, 0, 1'b0, 1'b1, "R3 err clear all");
    drive(4'h0, 4'h0, 4'h0, 4'h0, 10'h3FF, 0, 1'b0, 1'b1, "R6 all enabled idle");
    drive(4'h0, 4'h0, 4'h0, 4'h0, 10'h000, 0, 1'b0, 1'b1, "R9 all masked");

    @(negedge clk);
    repeat (3) @(posedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule